// File: doc/BRIEF.md
# Hardwired Control Timing Sequencer

This block is the front end of a hardwired control unit for a small 16-bit accumulator machine. A 4-bit step counter acts as the state register. Its value is expanded into sixteen one-hot timing lines. The current step, together with the stored indirect flag, selects a named phase. Each phase drives a fixed set of load and read strobes for the program counter, the address register, the instruction register and the memory port. The instruction register splits the word into three parts: an indirect flag in bit 15, an operation code in bits 14 to 12, and a 12-bit address in bits 11 to 0. The operation code is expanded into eight one-hot operation lines.

The phases and their transitions are as follows:

- **PH_FETCH_ADDR** (step 0) moves to **PH_FETCH_READ** (step 1).
- **PH_FETCH_READ** moves to **PH_DECODE** (step 2).
- **PH_DECODE** moves to step 3. Step 3 is **PH_INDIRECT** when the stored flag is 1, and otherwise the first cycle of **PH_EXEC**.
- **PH_INDIRECT** moves to **PH_EXEC** (step 4).
- **PH_EXEC** stays in place while the counter keeps stepping.
- The `exec_done` input takes any phase back to **PH_FETCH_ADDR** on the next cycle.
- A counter that runs past step 15 with no clear also returns to **PH_FETCH_ADDR**, and this raises a sticky error.

The memory port sits outside the block and must supply the word at `mem_addr` during the cycle in which it is read.

Top module: `hw_seq_ctrl`

## Requirements
- R1: While `rst` is high at a rising edge, the following are cleared: the step counter (so `t_line` = 16'h0001), `pc`, `mem_addr`, `ir`, `ind_flag` and `seq_err`.
- R2: `t_line` always has exactly one bit set, equal to 1 shifted left by the step count. With `exec_done` low and a step count below 15, the count rises by one at each edge.
- R3: With `exec_done` high at an edge, the next step count is 0, whatever the current step. Clear wins over increment.
- R4: At step 0, `ld_ar_pc` is high and `mem_addr` takes the value of `pc`.
- R5: At step 1, `mem_rd`, `ld_ir` and `inc_pc` are high. `ir` takes `mem_rdata`, and `pc` increments modulo 4096.
- R6: At step 2, `ld_ar_ir` is high. `mem_addr` takes `ir[11:0]` and `ind_flag` takes `ir[15]`. At all times, `d_line` is the one-hot expansion of `ir[14:12]`, with bit n high for code n.
- R7: At step 3 with `ind_flag` = 1, `mem_rd` and `ld_ar_mem` are high and `mem_addr` takes `mem_rdata[11:0]`. With `ind_flag` = 0, neither strobe is raised and `mem_addr` holds.
- R8: Exactly one phase output is high at any time:
  - `ph_fetch` at steps 0 and 1;
  - `ph_decode` at step 2;
  - `ph_indirect` at step 3 with `ind_flag` = 1;
  - `ph_exec` at all other times.
- R9: At step 15 with `exec_done` low, the count wraps to 0 and `seq_err` goes high. `seq_err` then stays high until reset.
- R10: `pc`, `ir`, `ind_flag` and `mem_addr` change only in the cycle whose strobe enables them. No strobe is raised from step 4 upward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Single clock for every register |
| rst | input | 1 | Synchronous reset, active high |
| exec_done | input | 1 | Clears the step counter at the next edge |
| mem_rdata | input | 16 | Word read from memory at `mem_addr` |
| mem_addr | output | 12 | Address register contents |
| mem_rd | output | 1 | Memory read strobe |
| t_line | output | 16 | One-hot timing lines |
| d_line | output | 8 | One-hot operation lines |
| ind_flag | output | 1 | Stored indirect flag |
| pc | output | 12 | Program counter |
| ir | output | 16 | Instruction register |
| ph_fetch | output | 1 | Fetch phase |
| ph_decode | output | 1 | Decode phase |
| ph_indirect | output | 1 | Indirect address read phase |
| ph_exec | output | 1 | Execute phase |
| ld_ar_pc | output | 1 | Address register loads from `pc` |
| ld_ir | output | 1 | Instruction register loads from memory |
| inc_pc | output | 1 | Program counter increments |
| ld_ar_ir | output | 1 | Address register loads from the instruction address field |
| ld_ar_mem | output | 1 | Address register loads from memory |
| seq_err | output | 1 | Sticky counter wrap error |

## Verification
The memory is modelled as a computed word per address, so the indirect bit and the opcode vary from one instruction to the next. This exercises the direct and indirect branches at step 3 against each other.

Random `exec_done` pulses land mostly in execute but sometimes during fetch or decode. These aborts separate clear priority from plain stepping, and show which strobes still act in the aborted cycle.

A long run with no clear drives the counter through step 15. It shows the wrap and the sticky error, and a later reset shows that the error clears.

// File: rtl/hw_seq_pkg.sv
package hw_seq_pkg;
    typedef enum logic [2:0] {
        PH_FETCH_ADDR,
        PH_FETCH_READ,
        PH_DECODE,
        PH_INDIRECT,
        PH_EXEC
    } phase_t;
endpackage

// File: rtl/hw_seq_onehot.sv
module hw_seq_onehot #(
    parameter int IN_W = 3,
    localparam int OUT_N = 1 << IN_W
) (
    input  logic [IN_W-1:0]  code,
    output logic [OUT_N-1:0] lines
);
    for (genvar k = 0; k < OUT_N; k++) begin : g_line
        assign lines[k] = (code == IN_W'(k));
    end
endmodule

// File: rtl/hw_seq_counter.sv
module hw_seq_counter #(
    parameter int SC_W = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            clr,
    output logic [SC_W-1:0] count,
    output logic            wrap_err
);
    localparam logic [SC_W-1:0] LAST = '1;

    always_ff @(posedge clk) begin
        if (rst) begin
            count    <= '0;
            wrap_err <= 1'b0;
        end else if (clr) begin
            count <= '0;
        end else begin
            count <= count + 1'b1;
            if (count == LAST) wrap_err <= 1'b1;
        end
    end
endmodule

// File: rtl/hw_seq_ctrl.sv
module hw_seq_ctrl #(
    parameter int WORD_W = 16,
    parameter int ADDR_W = 12,
    parameter int OP_W   = 3,
    parameter int SC_W   = 4,
    localparam int D_N   = 1 << OP_W,
    localparam int T_N   = 1 << SC_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              exec_done,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_rd,
    output logic [T_N-1:0]    t_line,
    output logic [D_N-1:0]    d_line,
    output logic              ind_flag,
    output logic [ADDR_W-1:0] pc,
    output logic [WORD_W-1:0] ir,
    output logic              ph_fetch,
    output logic              ph_decode,
    output logic              ph_indirect,
    output logic              ph_exec,
    output logic              ld_ar_pc,
    output logic              ld_ir,
    output logic              inc_pc,
    output logic              ld_ar_ir,
    output logic              ld_ar_mem,
    output logic              seq_err
);
    import hw_seq_pkg::*;

    localparam int IND_BIT = WORD_W - 1;

    logic [SC_W-1:0] step;
    phase_t          phase;

    hw_seq_counter #(.SC_W(SC_W)) u_counter (
        .clk      (clk),
        .rst      (rst),
        .clr      (exec_done),
        .count    (step),
        .wrap_err (seq_err)
    );

    hw_seq_onehot #(.IN_W(SC_W)) u_tdec (
        .code  (step),
        .lines (t_line)
    );

    hw_seq_onehot #(.IN_W(OP_W)) u_ddec (
        .code  (ir[ADDR_W +: OP_W]),
        .lines (d_line)
    );

    // Phase selection from the step count and the stored indirect flag
    always_comb begin
        unique case (step)
            SC_W'(0): phase = PH_FETCH_ADDR;
            SC_W'(1): phase = PH_FETCH_READ;
            SC_W'(2): phase = PH_DECODE;
            SC_W'(3): phase = ind_flag ? PH_INDIRECT : PH_EXEC;
            default:  phase = PH_EXEC;
        endcase
    end

    // Strobes per phase
    always_comb begin
        ph_fetch    = 1'b0;
        ph_decode   = 1'b0;
        ph_indirect = 1'b0;
        ph_exec     = 1'b0;
        ld_ar_pc    = 1'b0;
        ld_ir       = 1'b0;
        inc_pc      = 1'b0;
        ld_ar_ir    = 1'b0;
        ld_ar_mem   = 1'b0;
        mem_rd      = 1'b0;
        unique case (phase)
            PH_FETCH_ADDR: begin
                ph_fetch = 1'b1;
                ld_ar_pc = 1'b1;
            end
            PH_FETCH_READ: begin
                ph_fetch = 1'b1;
                mem_rd   = 1'b1;
                ld_ir    = 1'b1;
                inc_pc   = 1'b1;
            end
            PH_DECODE: begin
                ph_decode = 1'b1;
                ld_ar_ir  = 1'b1;
            end
            PH_INDIRECT: begin
                ph_indirect = 1'b1;
                mem_rd      = 1'b1;
                ld_ar_mem   = 1'b1;
            end
            PH_EXEC: begin
                ph_exec = 1'b1;
            end
            default: ;
        endcase
    end

    // Datapath registers, each behind its own enable
    always_ff @(posedge clk) begin
        if (rst) begin
            pc       <= '0;
            mem_addr <= '0;
            ir       <= '0;
            ind_flag <= 1'b0;
        end else begin
            if (inc_pc)    pc       <= pc + 1'b1;
            if (ld_ir)     ir       <= mem_rdata;
            if (ld_ar_ir)  ind_flag <= ir[IND_BIT];
            if (ld_ar_pc)  mem_addr <= pc;
            if (ld_ar_ir)  mem_addr <= ir[ADDR_W-1:0];
            if (ld_ar_mem) mem_addr <= mem_rdata[ADDR_W-1:0];
        end
    end
endmodule

// File: rtl/hw_seq_ctrl_chk.sv
module hw_seq_ctrl_chk #(
    parameter int ADDR_W = 12,
    parameter int WORD_W = 16,
    parameter int D_N    = 8,
    parameter int T_N    = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              exec_done,
    input logic [T_N-1:0]    t_line,
    input logic [D_N-1:0]    d_line,
    input logic [ADDR_W-1:0] pc,
    input logic [WORD_W-1:0] ir,
    input logic              ind_flag,
    input logic              ph_fetch,
    input logic              ph_decode,
    input logic              ph_indirect,
    input logic              ph_exec,
    input logic              inc_pc,
    input logic              ld_ir,
    input logic              ld_ar_ir,
    input logic              seq_err
);
    a_r2_onehot: assert property (@(posedge clk) disable iff (rst)
        $countones(t_line) == 1);
    a_r2_step: assert property (@(posedge clk) disable iff (rst)
        (!exec_done && !t_line[T_N-1]) |=> (t_line == ($past(t_line) << 1)));
    a_r3_clear: assert property (@(posedge clk) disable iff (rst)
        exec_done |=> t_line[0]);
    a_r5_pc_inc: assert property (@(posedge clk) disable iff (rst)
        inc_pc |=> (pc == $past(pc) + 1'b1));
    a_r6_dline: assert property (@(posedge clk) disable iff (rst)
        $countones(d_line) == 1);
    a_r8_phase: assert property (@(posedge clk) disable iff (rst)
        $countones({ph_fetch, ph_decode, ph_indirect, ph_exec}) == 1);
    a_r9_wrap: assert property (@(posedge clk) disable iff (rst)
        (t_line[T_N-1] && !exec_done) |=> (seq_err && t_line[0]));
    a_r9_sticky: assert property (@(posedge clk) disable iff (rst)
        seq_err |=> seq_err);
    a_r10_pc_hold: assert property (@(posedge clk) disable iff (rst)
        !inc_pc |=> $stable(pc));
    a_r10_ir_hold: assert property (@(posedge clk) disable iff (rst)
        !ld_ir |=> $stable(ir));
    a_r10_ind_hold: assert property (@(posedge clk) disable iff (rst)
        !ld_ar_ir |=> $stable(ind_flag));
endmodule

bind hw_seq_ctrl hw_seq_ctrl_chk #(
    .ADDR_W(ADDR_W), .WORD_W(WORD_W), .D_N(D_N), .T_N(T_N)
) u_chk (
    .clk(clk), .rst(rst), .exec_done(exec_done), .t_line(t_line),
    .d_line(d_line), .pc(pc), .ir(ir), .ind_flag(ind_flag),
    .ph_fetch(ph_fetch), .ph_decode(ph_decode), .ph_indirect(ph_indirect),
    .ph_exec(ph_exec), .inc_pc(inc_pc), .ld_ir(ld_ir), .ld_ar_ir(ld_ar_ir),
    .seq_err(seq_err)
);

// File: tb/hw_seq_ctrl_bench.sv
module hw_seq_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        exec_done = 1'b0;
    logic [15:0] mem_rdata;
    logic [11:0] mem_addr;
    logic        mem_rd;
    logic [15:0] t_line;
    logic [7:0]  d_line;
    logic        ind_flag;
    logic [11:0] pc;
    logic [15:0] ir;
    logic        ph_fetch, ph_decode, ph_indirect, ph_exec;
    logic        ld_ar_pc, ld_ir, inc_pc, ld_ar_ir, ld_ar_mem;
    logic        seq_err;

    int n_checks = 0;
    int n_fail   = 0;

    // Bench model state
    int          m_sc;
    logic [11:0] m_pc, m_ar;
    logic [15:0] m_ir;
    logic        m_i, m_err;

    always #10 clk = ~clk;

    function automatic logic [15:0] mem_word(input logic [11:0] a);
        logic [31:0] v;
        v = {20'd0, a} * 32'd40503 + 32'h1234;
        return v[15:0] ^ {a[3:0], 12'd0};
    endfunction

    assign mem_rdata = mem_word(mem_addr);

    hw_seq_ctrl u_hw_seq_ctrl (
        .clk(clk), .rst(rst), .exec_done(exec_done), .mem_rdata(mem_rdata),
        .mem_addr(mem_addr), .mem_rd(mem_rd), .t_line(t_line), .d_line(d_line),
        .ind_flag(ind_flag), .pc(pc), .ir(ir), .ph_fetch(ph_fetch),
        .ph_decode(ph_decode), .ph_indirect(ph_indirect), .ph_exec(ph_exec),
        .ld_ar_pc(ld_ar_pc), .ld_ir(ld_ir), .inc_pc(inc_pc),
        .ld_ar_ir(ld_ar_ir), .ld_ar_mem(ld_ar_mem), .seq_err(seq_err)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [3:0] exp_phase(input int sc, input logic i);
        if (sc <= 1) return 4'b1000;
        if (sc == 2) return 4'b0100;
        if (sc == 3 && i) return 4'b0010;
        return 4'b0001;
    endfunction

    function automatic logic [4:0] exp_strobe(input int sc, input logic i);
        if (sc == 0) return 5'b10000;
        if (sc == 1) return 5'b01100;
        if (sc == 2) return 5'b00010;
        if (sc == 3 && i) return 5'b00001;
        return 5'b00000;
    endfunction

    // One clock: drive at the falling edge, check outputs, model the edge, check state
    task automatic step(input logic r, input logic ed);
        int          n_sc;
        logic [11:0] n_pc, n_ar;
        logic [15:0] n_ir;
        logic        n_i, n_err;
        string       ar_tag;
        rst = r;
        exec_done = ed;
        #1;
        if (!r) begin
            chk(t_line == 16'(1 << m_sc), "R2 t_line", 32'(t_line), 32'(1 << m_sc));
            chk(d_line == 8'(1 << m_ir[14:12]), "R6 d_line", 32'(d_line),
                32'(1 << m_ir[14:12]));
            chk({ph_fetch, ph_decode, ph_indirect, ph_exec} == exp_phase(m_sc, m_i),
                "R8 phase", 32'({ph_fetch, ph_decode, ph_indirect, ph_exec}),
                32'(exp_phase(m_sc, m_i)));
            chk({ld_ar_pc, ld_ir, inc_pc, ld_ar_ir, ld_ar_mem} == exp_strobe(m_sc, m_i),
                (m_sc >= 4) ? "R10 strobes" : "R4 R5 R6 R7 strobes",
                32'({ld_ar_pc, ld_ir, inc_pc, ld_ar_ir, ld_ar_mem}),
                32'(exp_strobe(m_sc, m_i)));
            chk(mem_rd == (m_sc == 1 || (m_sc == 3 && m_i)), "R5 R7 mem_rd",
                32'(mem_rd), 32'(m_sc == 1 || (m_sc == 3 && m_i)));
        end
        n_sc = m_sc; n_pc = m_pc; n_ar = m_ar; n_ir = m_ir; n_i = m_i; n_err = m_err;
        if (r) begin
            n_sc = 0; n_pc = '0; n_ar = '0; n_ir = '0; n_i = 1'b0; n_err = 1'b0;
        end else begin
            n_sc = ed ? 0 : (m_sc + 1) % 16;
            if (!ed && m_sc == 15) n_err = 1'b1;
            case (m_sc)
                0: n_ar = m_pc;
                1: begin n_ir = mem_word(m_ar); n_pc = m_pc + 12'd1; end
                2: begin n_ar = m_ir[11:0]; n_i = m_ir[15]; end
                3: if (m_i) n_ar = mem_word(m_ar)[11:0];
                default: ;
            endcase
        end
        ar_tag = (m_sc == 0) ? "R4 ar" : (m_sc == 2) ? "R6 ar" :
                 (m_sc == 3) ? "R7 ar" : "R10 ar";
        @(posedge clk);
        m_sc = n_sc; m_pc = n_pc; m_ar = n_ar; m_ir = n_ir; m_i = n_i; m_err = n_err;
        @(negedge clk);
        #1;
        chk(t_line == 16'(1 << m_sc), r ? "R1 t_line" : (ed ? "R3 clear" : "R2 step"),
            32'(t_line), 32'(1 << m_sc));
        chk(pc == m_pc, r ? "R1 pc" : "R5 R10 pc", 32'(pc), 32'(m_pc));
        chk(mem_addr == m_ar, r ? "R1 ar" : ar_tag, 32'(mem_addr), 32'(m_ar));
        chk(ir == m_ir, r ? "R1 ir" : "R5 R10 ir", 32'(ir), 32'(m_ir));
        chk(ind_flag == m_i, r ? "R1 ind" : "R6 R10 ind", 32'(ind_flag), 32'(m_i));
        chk(seq_err == m_err, r ? "R1 err" : "R9 err", 32'(seq_err), 32'(m_err));
    endtask

    initial begin
        #(20 * 200000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240607));
        m_sc = 0; m_pc = '0; m_ar = '0; m_ir = '0; m_i = 1'b0; m_err = 1'b0;
        @(negedge clk);
        // R1: reset
        for (int k = 0; k < 3; k++) step(1'b1, 1'b0);
        // Directed: two full instructions ending in execute
        for (int n = 0; n < 2; n++) begin
            for (int k = 0; k < 6; k++) step(1'b0, 1'b0);
            step(1'b0, 1'b1);
        end
        // Directed R3: clear during fetch read and during decode
        step(1'b0, 1'b0);
        step(1'b0, 1'b1);
        for (int k = 0; k < 2; k++) step(1'b0, 1'b0);
        step(1'b0, 1'b1);
        // Random mix of execute lengths and aborts
        for (int k = 0; k < 4000; k++) begin
            logic ed;
            if (m_sc >= 3) ed = ($urandom % 5) == 0;
            else           ed = ($urandom % 40) == 0;
            step(1'b0, ed);
        end
        step(1'b0, 1'b1);
        // R9: run through step 15 with no clear, error stays set across clears
        for (int k = 0; k < 20; k++) step(1'b0, 1'b0);
        step(1'b0, 1'b1);
        for (int k = 0; k < 5; k++) step(1'b0, 1'b0);
        // R1: reset clears the sticky error
        step(1'b1, 1'b0);
        for (int k = 0; k < 8; k++) step(1'b0, 1'b0);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule